// File: doc/BRIEF.md
# Auxiliary Timer with Remote Run

This block is a 16-bit up/down timer that works beside a core timer. It has four ways of stepping its count. It can count a divided system clock. It can count that clock only while an external gate is at a chosen level. It can count chosen edges of an external pin. It can also count overflow strobes from the core timer, so the two timers act as one longer counter. Counting starts and stops under a run bit. That bit is either the block's own bit or the core timer's run bit, so several timers can start and stop on the same cycle.

A capture register takes a copy of the live count when a trigger occurs. The trigger is either a chosen edge of a capture pin or a strobe from inside the chip. A sticky flag records that a capture happened. The CPU reaches the control, count, capture and status words through a simple register port. It may load the count at any time.

Top module: `aux_timer`

## Requirements
- R1: After synchronous reset, the count, the capture word, the control word, the capture flag and the wrap pulse are all zero.
- R2: In mode 00 (timer), the count steps once every 2^(3+n) clock cycles while the selected run bit is set, where n is the prescale field in control bits [4:2]. The first step comes 2^(3+n) cycles after the run bit takes effect, because the divider restarts from zero whenever the run bit is clear.
- R3: When control bit 5 (down) is set, each step decrements the count; when it is clear, each step increments the count.
- R4: In mode 01 (gated), the count steps at the timer rate only while the synchronized pin tin_i equals control bit 6. Bit 6 = 1 makes high the active level and 0 makes low the active level. At any other pin level the count holds.
- R5: In mode 10 (counter), the count steps on edges of tin_i, chosen by control bits [10:9]. The codes are 00 = never, 01 = rising, 10 = falling and 11 = both. The pin passes through a two-flop synchronizer before edge detection.
- R6: In mode 11 (chained), the count steps once for each clock cycle in which core_ovf_i is high.
- R7: Control bit 8 (remote) selects the run source: 0 uses control bit 7, and 1 uses core_run_i. The run source that is not selected has no effect.
- R8: While the selected run bit is clear, the count holds its value in every mode.
- R9: Counting wraps modulo 2^16 in both directions. On the cycle after a step from FFFF up or from 0000 down, wrap_o is high for exactly one cycle.
- R10: A write to the count register (address 1) loads wr_data, and takes priority over a step in the same cycle.
- R11: Capture copies the current count into the capture register (read at address 2). When control bit 13 is 0, the trigger is an edge of the synchronized cap_pin_i chosen by control bits [12:11], with the same codes as R5. When bit 13 is 1, the trigger is a high cycle of cap_trig_i and the pin is ignored.
- R12: A capture sets cap_flag_o, which stays set until a write to address 3 with bit 0 = 1 clears it. A write with bit 0 = 0 leaves the flag set.
- R13: rd_data returns the addressed word one cycle after rd_addr is presented. The addresses are 0 = control, 1 = count, 2 = capture, and 3 = status with the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| core_run_i | input | 1 | Run bit of the core timer |
| core_ovf_i | input | 1 | Overflow strobe of the core timer |
| tin_i | input | 1 | External gate / count pin |
| cap_pin_i | input | 1 | External capture pin |
| cap_trig_i | input | 1 | Internal capture strobe |
| count_o | output | 16 | Live count value |
| wrap_o | output | 1 | One-cycle wrap pulse |
| cap_flag_o | output | 1 | Sticky capture flag |

## Verification
The assertions watch, on every cycle, the following rules:
- A load wins over a step.
- A step moves the count by exactly one.
- An idle or remotely stopped counter holds its value.
- Divider ticks never come back to back.
- Capture copies the count of the trigger cycle.
- The flag stays set until a clear that really writes 1.
- Wrap pulses happen only at the two wrap values.

Only the bench scenarios can show the following:
- The divide ratios for several prescale settings.
- The effect of the gate polarity.
- Each edge-select code on both pins.
- That the non-selected run source and a disabled trigger source have no effect.

// File: rtl/aux_tmr_pkg.sv
package aux_tmr_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_GATED = 2'b01,
    MODE_COUNT = 2'b10,
    MODE_CHAIN = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic [1:0] spare;
    logic       cap_int;
    logic [1:0] cap_edge;
    logic [1:0] cnt_edge;
    logic       remote;
    logic       run;
    logic       gate_hi;
    logic       down;
    logic [2:0] psc;
    tmr_mode_e  mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_CAP  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

endpackage

// File: rtl/aux_tmr_prescaler.sv
module aux_tmr_prescaler #(
  parameter int SEL_W = 3,
  parameter int BASE  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = BASE + (1 << SEL_W) - 1;

  logic [CW-1:0] div_q;
  logic [CW-1:0] mask;

  always_comb begin
    mask = (CW'(1) << (CW'(BASE) + CW'(sel))) - CW'(1);
    tick = run && ((div_q & mask) == mask);
  end

  // the divider restarts whenever the run source is low
  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + CW'(1);
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R2

endmodule

// File: rtl/aux_tmr_edge.sv
module aux_tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       level,
  output logic       hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  always_comb begin
    level = sync_q[STAGES-1];
    rise  = level & ~prev_q;
    fall  = ~level & prev_q;
    hit   = (sel[0] & rise) | (sel[1] & fall);
  end

  AST_HIT_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |-> !hit); // R5

endmodule

// File: rtl/aux_tmr_counter.sv
module aux_tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (load) begin
        count <= load_val;
      end else if (step) begin
        count <= down ? count - ONE : count + ONE;
        wrap  <= down ? (count == '0) : (count == '1);
      end
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val)); // R10
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !down) |=> count == $past(count) + ONE); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (step && !load && down) |=> count == $past(count) - ONE); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(count)); // R8

endmodule

// File: rtl/aux_timer.sv
module aux_timer
  import aux_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int PSC_W  = 3,
  parameter int PSC_B  = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              core_run_i,
  input  logic              core_ovf_i,
  input  logic              tin_i,
  input  logic              cap_pin_i,
  input  logic              cap_trig_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o,
  output logic              cap_flag_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;
  logic             run_sel, tick, step, load, cap_fire;
  logic             tin_lvl, tin_hit, cpin_lvl, cpin_hit;
  logic             wr_ctrl, wr_stat, flag_clr;

  always_comb begin
    wr_ctrl  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    load     = wr_en && (wr_addr == ADDR_W'(ADDR_CNT));
    wr_stat  = wr_en && (wr_addr == ADDR_W'(ADDR_STAT));
    flag_clr = wr_stat && wr_data[0];
    run_sel  = ctrl_q.remote ? core_run_i : ctrl_q.run;
  end

  aux_tmr_prescaler #(.SEL_W(PSC_W), .BASE(PSC_B)) u_psc (
    .clk (clk), .rst (rst), .run (run_sel), .sel (ctrl_q.psc), .tick (tick)
  );

  aux_tmr_edge #(.STAGES(SYNC_N)) u_tin (
    .clk (clk), .rst (rst), .pin (tin_i), .sel (ctrl_q.cnt_edge),
    .level (tin_lvl), .hit (tin_hit)
  );

  aux_tmr_edge #(.STAGES(SYNC_N)) u_cpin (
    .clk (clk), .rst (rst), .pin (cap_pin_i), .sel (ctrl_q.cap_edge),
    .level (cpin_lvl), .hit (cpin_hit)
  );

  always_comb begin
    case (ctrl_q.mode)
      MODE_TIMER: step = run_sel && tick;
      MODE_GATED: step = run_sel && tick && (tin_lvl == ctrl_q.gate_hi);
      MODE_COUNT: step = run_sel && tin_hit;
      default:    step = run_sel && core_ovf_i;
    endcase
    cap_fire = ctrl_q.cap_int ? cap_trig_i : cpin_hit;
  end

  aux_tmr_counter #(.W(CNT_W)) u_cnt (
    .clk (clk), .rst (rst), .load (load), .load_val (wr_data),
    .step (step), .down (ctrl_q.down), .count (count_o), .wrap (wrap_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl)       ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (cap_fire)      cap_q  <= count_o;
      if (cap_fire)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(ADDR_CTRL): rd_data <= CNT_W'(ctrl_q);
        ADDR_W'(ADDR_CNT):  rd_data <= count_o;
        ADDR_W'(ADDR_CAP):  rd_data <= cap_q;
        default:            rd_data <= CNT_W'(flag_q);
      endcase
    end
  end

  assign cap_flag_o = flag_q;

  AST_CAP_COPY: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> cap_q == $past(count_o)); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q); // R12
  AST_WRAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (count_o == '0 || count_o == '1)); // R9
  AST_REMOTE_STOP: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.remote && !core_run_i && !load) |=> $stable(count_o)); // R7

endmodule

// File: tb/aux_timer_tb_top.sv
module aux_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        core_run_i = 1'b0, core_ovf_i = 1'b0;
  logic        tin_i = 1'b0, cap_pin_i = 1'b0, cap_trig_i = 1'b0;
  logic [15:0] count_o;
  logic        wrap_o, cap_flag_o;

  int checks = 0;
  int errors = 0;
  int wrap_cnt = 0;
  bit done = 0;

  typedef struct {
    int          src;   // 0 count, 1 rd_data, 2 flag, 3 wrap pulses
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  aux_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .core_run_i(core_run_i),
    .core_ovf_i(core_ovf_i), .tin_i(tin_i), .cap_pin_i(cap_pin_i),
    .cap_trig_i(cap_trig_i), .count_o(count_o), .wrap_o(wrap_o),
    .cap_flag_o(cap_flag_o)
  );

  always @(negedge clk) if (!rst && wrap_o) wrap_cnt++;

  // monitor: pops expected items and compares
  initial begin
    item_t it;
    logic [15:0] obs;
    forever begin
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      case (it.src)
        0:       obs = count_o;
        1:       obs = rd_data;
        2:       obs = 16'(cap_flag_o);
        default: obs = 16'(wrap_cnt);
      endcase
      checks++;
      if (obs !== it.exp) begin
        errors++;
        $display("FAIL %s src=%0d actual=%h expected=%h", it.tag, it.src, obs, it.exp);
      end
    end
  end

  task automatic expect_val(input int src, input logic [15:0] exp, input string tag);
    item_t it;
    it.src = src; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [15:0] exp, input string tag);
    rd_addr = a;
    @(negedge clk);
    expect_val(1, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ovf_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      core_ovf_i = 1'b1; @(negedge clk);
      core_ovf_i = 1'b0; @(negedge clk);
    end
  endtask

  task automatic tin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tin_i = 1'b1; idle(3);
      tin_i = 1'b0; idle(3);
    end
    idle(5);
  endtask

  function automatic logic [15:0] cfg(input int mode, input int psc, input int down,
                                      input int gate_hi, input int run, input int remote,
                                      input int cedge, input int kedge, input int cint);
    cfg = 16'(mode) | (16'(psc) << 2) | (16'(down) << 5) | (16'(gate_hi) << 6) |
          (16'(run) << 7) | (16'(remote) << 8) | (16'(cedge) << 9) |
          (16'(kedge) << 11) | (16'(cint) << 13);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    expect_val(0, 16'h0000, "R1");
    expect_val(2, 16'h0000, "R1");
    expect_val(3, 16'h0000, "R1");
    rd_expect(2'd0, 16'h0000, "R1");
    rd_expect(2'd2, 16'h0000, "R1");

    // R2 timer divide by 8, 80 cycles -> 10
    wr(2'd0, cfg(0, 0, 0, 0, 1, 0, 0, 0, 0));
    idle(79);
    wr(2'd0, cfg(0, 0, 0, 0, 0, 0, 0, 0, 0));
    expect_val(0, 16'd10, "R2");
    // R8 hold while stopped
    idle(40);
    expect_val(0, 16'd10, "R8");
    // R3 down, divide by 16, 64 cycles: 5 -> 1
    wr(2'd1, 16'd5);
    wr(2'd0, cfg(0, 1, 1, 0, 1, 0, 0, 0, 0));
    idle(63);
    wr(2'd0, cfg(0, 1, 1, 0, 0, 0, 0, 0, 0));
    expect_val(0, 16'd1, "R3");
    // R2 divide by 32, 96 cycles -> 3
    wr(2'd1, 16'd0);
    wr(2'd0, cfg(0, 2, 0, 0, 1, 0, 0, 0, 0));
    idle(95);
    wr(2'd0, cfg(0, 2, 0, 0, 0, 0, 0, 0, 0));
    expect_val(0, 16'd3, "R2");

    // R4 gated, active high, gate low -> no count
    wr(2'd1, 16'd0);
    wr(2'd0, cfg(1, 0, 0, 1, 1, 0, 0, 0, 0));
    idle(79);
    wr(2'd0, cfg(1, 0, 0, 1, 0, 0, 0, 0, 0));
    expect_val(0, 16'd0, "R4");
    tin_i = 1'b1; idle(5);
    wr(2'd0, cfg(1, 0, 0, 1, 1, 0, 0, 0, 0));
    idle(79);
    wr(2'd0, cfg(1, 0, 0, 1, 0, 0, 0, 0, 0));
    expect_val(0, 16'd10, "R4");
    // R4 active low
    tin_i = 1'b0; idle(5);
    wr(2'd1, 16'd0);
    wr(2'd0, cfg(1, 0, 0, 0, 1, 0, 0, 0, 0));
    idle(79);
    wr(2'd0, cfg(1, 0, 0, 0, 0, 0, 0, 0, 0));
    expect_val(0, 16'd10, "R4");

    // R5 counter mode edge selects
    wr(2'd1, 16'd0);
    wr(2'd0, cfg(2, 0, 0, 0, 1, 0, 1, 0, 0));
    tin_pulses(3);
    expect_val(0, 16'd3, "R5");
    wr(2'd0, cfg(2, 0, 0, 0, 1, 0, 3, 0, 0));
    tin_pulses(3);
    expect_val(0, 16'd9, "R5");
    wr(2'd0, cfg(2, 0, 0, 0, 1, 0, 2, 0, 0));
    tin_pulses(3);
    expect_val(0, 16'd12, "R5");
    wr(2'd0, cfg(2, 0, 0, 0, 1, 0, 0, 0, 0));
    tin_pulses(3);
    expect_val(0, 16'd12, "R5");

    // R6 chained to core overflows
    wr(2'd1, 16'd0);
    wr(2'd0, cfg(3, 0, 0, 0, 1, 0, 0, 0, 0));
    ovf_pulses(4);
    expect_val(0, 16'd4, "R6");
    // R9 wrap up and down
    wr(2'd1, 16'hFFFE);
    ovf_pulses(2);
    expect_val(0, 16'h0000, "R9");
    expect_val(3, 16'd1, "R9");
    wr(2'd0, cfg(3, 0, 1, 0, 1, 0, 0, 0, 0));
    wr(2'd1, 16'h0001);
    ovf_pulses(2);
    expect_val(0, 16'hFFFF, "R9");
    expect_val(3, 16'd2, "R9");
    // R10 write beats step in the same cycle
    wr(2'd0, cfg(3, 0, 0, 0, 1, 0, 0, 0, 0));
    core_ovf_i = 1'b1;
    wr(2'd1, 16'h1234);
    core_ovf_i = 1'b0;
    expect_val(0, 16'h1234, "R10");

    // R7 remote run source
    wr(2'd0, cfg(3, 0, 0, 0, 0, 1, 0, 0, 0));
    wr(2'd1, 16'd0);
    core_run_i = 1'b1;
    ovf_pulses(3);
    expect_val(0, 16'd3, "R7");
    core_run_i = 1'b0;
    ovf_pulses(2);
    expect_val(0, 16'd3, "R7");
    wr(2'd0, cfg(3, 0, 0, 0, 1, 1, 0, 0, 0));
    ovf_pulses(2);
    expect_val(0, 16'd3, "R7");
    wr(2'd0, cfg(3, 0, 0, 0, 1, 0, 0, 0, 0));
    ovf_pulses(2);
    expect_val(0, 16'd5, "R7");

    // R11 R12 capture from pin, rising edge
    wr(2'd0, cfg(0, 0, 0, 0, 0, 0, 0, 1, 0));
    wr(2'd1, 16'h00AB);
    cap_pin_i = 1'b1; idle(5);
    expect_val(2, 16'd1, "R12");
    rd_expect(2'd2, 16'h00AB, "R11");
    rd_expect(2'd3, 16'h0001, "R13");
    wr(2'd3, 16'h0000);
    idle(2);
    expect_val(2, 16'd1, "R12");
    wr(2'd3, 16'h0001);
    expect_val(2, 16'd0, "R12");
    wr(2'd1, 16'h00CD);
    cap_pin_i = 1'b0; idle(5);
    expect_val(2, 16'd0, "R11");
    rd_expect(2'd2, 16'h00AB, "R11");
    // falling-edge select
    wr(2'd0, cfg(0, 0, 0, 0, 0, 0, 0, 2, 0));
    cap_pin_i = 1'b1; idle(5);
    expect_val(2, 16'd0, "R11");
    cap_pin_i = 1'b0; idle(5);
    expect_val(2, 16'd1, "R11");
    rd_expect(2'd2, 16'h00CD, "R11");
    wr(2'd3, 16'h0001);
    // internal trigger, pin ignored
    wr(2'd0, cfg(0, 0, 0, 0, 0, 0, 0, 3, 1));
    wr(2'd1, 16'h0777);
    cap_pin_i = 1'b1; idle(5);
    expect_val(2, 16'd0, "R11");
    rd_expect(2'd2, 16'h00CD, "R11");
    cap_trig_i = 1'b1; @(negedge clk); cap_trig_i = 1'b0;
    idle(1);
    expect_val(2, 16'd1, "R12");
    rd_expect(2'd2, 16'h0777, "R11");
    // R13 control readback
    rd_expect(2'd0, cfg(0, 0, 0, 0, 0, 0, 0, 3, 1), "R13");
    rd_expect(2'd1, 16'h0777, "R13");

    wait (sb_q.size() == 0);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule